// File: doc/BRIEF.md
# Dual-Read Write-Through Level-One Data Cache

This block is a small direct-mapped first-level data cache for a load/store pipeline. Two load lanes can look up the array in the same cycle through separate read ports, and one store can be accepted alongside them. Each lane returns one 64-bit word, so together they deliver 16 bytes per cycle. A load hit answers exactly two cycles after its request. A load miss does not stall anything. It comes out on a per-lane miss lane that feeds an external miss-tracking unit, and loads issued after it keep hitting.

Stores follow a write-through policy. Every store is passed downstream one cycle after it is accepted. A store that hits also updates the stored word. A store that misses leaves the cache unchanged, so no line is allocated. Whole lines come back from the next level through a fill port that writes the tag, the valid flag and all words of a line in one cycle. With the default parameters the cache holds 8 KB as 256 lines of 32 bytes, and each line is addressed as four 64-bit words. Coherence and address translation belong to other blocks.

Top module: `l1d_cache`

## Requirements
- R1: After reset every line is invalid, so the first load to any address reports a miss, and all valid outputs are low during reset.
- R2: A load request accepted in cycle t produces a response on the same lane in cycle t+2. No response appears in any other cycle.
- R3: Both load lanes work independently in the same cycle, for the same or for different addresses.
- R4: A fill carries a line address {tag, index} and 256 bits of data, with word k at bits [64k+63:64k]. From the following cycle, loads to any of the line's words hit with that data. The word is selected by address bits [4:3], the index by bits [12:5] and the tag by bits [31:13]. Bits [2:0] do not select anything.
- R5: A store that hits updates its word. A load requested in the same cycle as the store, or later, sees the new value.
- R6: Every store, hit or miss, appears on the write-through output the next cycle with its address and data unchanged.
- R7: A store miss does not allocate. A later load to that address still misses.
- R8: A miss response has hit low and data zero. In the same cycle the miss lane carries the full load address. Later hits on either lane are not delayed.
- R9: If a fill writes a line in the cycle after a load request to that index, the fill wins and the load reports a miss.
- R10: A fill with a different tag at an occupied index evicts the old line. Loads to the old tag then miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_req_valid_i | input | 2 | Load request per lane |
| ld_req_addr_i | input | 2x32 | Byte address per lane |
| ld_rsp_valid_o | output | 2 | Response valid per lane |
| ld_rsp_hit_o | output | 2 | Response was a hit |
| ld_rsp_data_o | output | 2x64 | Loaded word (zero on miss) |
| miss_valid_o | output | 2 | Miss handed to the miss tracker |
| miss_addr_o | output | 2x32 | Address of the missing load |
| st_valid_i | input | 1 | Store request |
| st_addr_i | input | 32 | Store byte address |
| st_data_i | input | 64 | Store word |
| wt_valid_o | output | 1 | Write-through to the next level |
| wt_addr_o | output | 32 | Forwarded store address |
| wt_data_o | output | 64 | Forwarded store word |
| fill_valid_i | input | 1 | Line fill from the next level |
| fill_line_i | input | 27 | Line address {tag, index} |
| fill_data_i | input | 256 | Line contents |

## Verification
The assertions check the following on every cycle:
- the fixed two-cycle response timing on each lane;
- that a fill to the looked-up index forces a miss;
- that the miss lane repeats the address requested two cycles earlier;
- that every store is forwarded unchanged the next cycle;
- that a store hit lands in the array;
- that a fill sets the valid flag of its line.

Only the bench scenarios can show the following:
- that data returned by a hit is the most recent value;
- that a store miss leaves later loads missing;
- that a conflicting fill evicts the old tag;
- that a miss on one lane leaves hits on the other lane and on later loads unaffected.

// File: rtl/l1d_pkg.sv
package l1d_pkg;
  localparam int unsigned DEF_ADDR_W      = 32;
  localparam int unsigned DEF_CACHE_BYTES = 8192;
  localparam int unsigned DEF_LINE_BYTES  = 32;
  localparam int unsigned DEF_WORD_W      = 64;
  localparam int unsigned DEF_N_LD        = 2;
endpackage

// File: rtl/l1d_tag_array.sv
module l1d_tag_array #(
  parameter int unsigned N_RD  = 3,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned TAG_W = 19
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_RD-1:0][IDX_W-1:0] rd_idx_i,
  output logic [N_RD-1:0]            rd_valid_o,
  output logic [N_RD-1:0][TAG_W-1:0] rd_tag_o,
  input  logic                      fill_we_i,
  input  logic [IDX_W-1:0]          fill_idx_i,
  input  logic [TAG_W-1:0]          fill_tag_i
);
  localparam int unsigned N_LINES = 2 ** IDX_W;

  logic [N_LINES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [N_LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (fill_we_i) valid_q[fill_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (fill_we_i) tag_q[fill_idx_i] <= fill_tag_i;
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_valid_o[r] = valid_q[rd_idx_i[r]];
    assign rd_tag_o[r]   = tag_q[rd_idx_i[r]];
  end

  AST_FILL_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_we_i |=> valid_q[$past(fill_idx_i)] && tag_q[$past(fill_idx_i)] == $past(fill_tag_i)); // R4
endmodule

// File: rtl/l1d_data_array.sv
module l1d_data_array #(
  parameter int unsigned N_RD   = 2,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned WSEL_W = 2,
  parameter int unsigned WORD_W = 64,
  localparam int unsigned WPL   = 2 ** WSEL_W,
  localparam int unsigned LINE_W = WPL * WORD_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_RD-1:0][IDX_W-1:0]  rd_idx_i,
  input  logic [N_RD-1:0][WSEL_W-1:0] rd_wsel_i,
  output logic [N_RD-1:0][WORD_W-1:0] rd_word_o,
  input  logic                        st_we_i,
  input  logic [IDX_W-1:0]            st_idx_i,
  input  logic [WSEL_W-1:0]           st_wsel_i,
  input  logic [WORD_W-1:0]           st_data_i,
  input  logic                        fill_we_i,
  input  logic [IDX_W-1:0]            fill_idx_i,
  input  logic [LINE_W-1:0]           fill_data_i
);
  localparam int unsigned N_LINES = 2 ** IDX_W;

  logic [WORD_W-1:0] mem_q [N_LINES][WPL];

  // Store first, fill second: a fill to the same index overrides.
  always_ff @(posedge clk_i) begin
    if (st_we_i) mem_q[st_idx_i][st_wsel_i] <= st_data_i;
    if (fill_we_i) begin
      for (int w = 0; w < WPL; w++) mem_q[fill_idx_i][w] <= fill_data_i[w*WORD_W +: WORD_W];
    end
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_word_o[r] = mem_q[rd_idx_i[r]][rd_wsel_i[r]];
  end

  AST_STORE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_we_i && !(fill_we_i && fill_idx_i == st_idx_i))
    |=> mem_q[$past(st_idx_i)][$past(st_wsel_i)] == $past(st_data_i)); // R5
endmodule

// File: rtl/l1d_load_pipe.sv
module l1d_load_pipe #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 64,
  parameter int unsigned OFF_W  = 3,
  parameter int unsigned WSEL_W = 2,
  parameter int unsigned IDX_W  = 8,
  localparam int unsigned IDX_LSB = OFF_W + WSEL_W,
  localparam int unsigned TAG_W   = ADDR_W - IDX_LSB - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic [WSEL_W-1:0] lk_wsel_o,
  input  logic              lk_valid_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [WORD_W-1:0] lk_word_i,
  input  logic              fill_valid_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic              miss_valid_o,
  output logic [ADDR_W-1:0] miss_addr_o
);
  logic              s1_valid_q;
  logic [ADDR_W-1:0] s1_addr_q;
  logic [TAG_W-1:0]  s1_tag;
  logic              fill_clash;
  logic              s1_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_addr_q  <= '0;
    end else begin
      s1_valid_q <= req_valid_i;
      if (req_valid_i) s1_addr_q <= req_addr_i;
    end
  end

  assign lk_idx_o   = s1_addr_q[IDX_LSB +: IDX_W];
  assign lk_wsel_o  = s1_addr_q[OFF_W +: WSEL_W];
  assign s1_tag     = s1_addr_q[ADDR_W-1 -: TAG_W];
  // a fill writing this index now wins; the load replays as a miss
  assign fill_clash = fill_valid_i && (fill_idx_i == lk_idx_o);
  assign s1_hit     = s1_valid_q && lk_valid_i && (lk_tag_i == s1_tag) && !fill_clash;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_hit_o    <= 1'b0;
      rsp_data_o   <= '0;
      miss_valid_o <= 1'b0;
      miss_addr_o  <= '0;
    end else begin
      rsp_valid_o  <= s1_valid_q;
      rsp_hit_o    <= s1_hit;
      rsp_data_o   <= s1_hit ? lk_word_i : '0;
      miss_valid_o <= s1_valid_q && !s1_hit;
      miss_addr_o  <= s1_valid_q ? s1_addr_q : '0;
    end
  end

  AST_HIT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ##1 rsp_valid_o); // R2
  AST_FILL_REPLAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && fill_valid_i && fill_idx_i == lk_idx_o) |=> (rsp_valid_o && !rsp_hit_o)); // R9
  AST_MISS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_o |-> miss_addr_o == $past(req_addr_i, 2)); // R8
endmodule

// File: rtl/l1d_cache.sv
module l1d_cache
  import l1d_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned CACHE_BYTES = DEF_CACHE_BYTES,
  parameter int unsigned LINE_BYTES  = DEF_LINE_BYTES,
  parameter int unsigned WORD_W      = DEF_WORD_W,
  parameter int unsigned N_LD        = DEF_N_LD,
  localparam int unsigned N_LINES = CACHE_BYTES / LINE_BYTES,
  localparam int unsigned WPL     = LINE_BYTES * 8 / WORD_W,
  localparam int unsigned OFF_W   = $clog2(WORD_W / 8),
  localparam int unsigned WSEL_W  = $clog2(WPL),
  localparam int unsigned IDX_W   = $clog2(N_LINES),
  localparam int unsigned IDX_LSB = OFF_W + WSEL_W,
  localparam int unsigned TAG_W   = ADDR_W - IDX_LSB - IDX_W,
  localparam int unsigned LINE_W  = WPL * WORD_W,
  localparam int unsigned LADDR_W = TAG_W + IDX_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_LD-1:0]             ld_req_valid_i,
  input  logic [N_LD-1:0][ADDR_W-1:0] ld_req_addr_i,
  output logic [N_LD-1:0]             ld_rsp_valid_o,
  output logic [N_LD-1:0]             ld_rsp_hit_o,
  output logic [N_LD-1:0][WORD_W-1:0] ld_rsp_data_o,
  output logic [N_LD-1:0]             miss_valid_o,
  output logic [N_LD-1:0][ADDR_W-1:0] miss_addr_o,
  input  logic                        st_valid_i,
  input  logic [ADDR_W-1:0]           st_addr_i,
  input  logic [WORD_W-1:0]           st_data_i,
  output logic                        wt_valid_o,
  output logic [ADDR_W-1:0]           wt_addr_o,
  output logic [WORD_W-1:0]           wt_data_o,
  input  logic                        fill_valid_i,
  input  logic [LADDR_W-1:0]          fill_line_i,
  input  logic [LINE_W-1:0]           fill_data_i
);
  localparam int unsigned N_TRD = N_LD + 1;  // load lanes plus store probe

  logic [N_TRD-1:0][IDX_W-1:0]  tag_rd_idx;
  logic [N_TRD-1:0]             tag_rd_valid;
  logic [N_TRD-1:0][TAG_W-1:0]  tag_rd_tag;
  logic [N_LD-1:0][IDX_W-1:0]   lk_idx;
  logic [N_LD-1:0][WSEL_W-1:0]  lk_wsel;
  logic [N_LD-1:0][WORD_W-1:0]  lk_word;

  logic [IDX_W-1:0]  fill_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic [IDX_W-1:0]  st_idx;
  logic [WSEL_W-1:0] st_wsel;
  logic [TAG_W-1:0]  st_tag;
  logic              st_hit;
  logic              st_we;

  assign fill_idx = fill_line_i[IDX_W-1:0];
  assign fill_tag = fill_line_i[LADDR_W-1 -: TAG_W];
  assign st_idx   = st_addr_i[IDX_LSB +: IDX_W];
  assign st_wsel  = st_addr_i[OFF_W +: WSEL_W];
  assign st_tag   = st_addr_i[ADDR_W-1 -: TAG_W];

  assign tag_rd_idx[N_LD] = st_idx;
  assign st_hit = st_valid_i && tag_rd_valid[N_LD] && (tag_rd_tag[N_LD] == st_tag);
  // no allocate on store miss; a same-index fill overrides the store
  assign st_we  = st_hit && !(fill_valid_i && fill_idx == st_idx);

  for (genvar p = 0; p < N_LD; p++) begin : g_lane
    assign tag_rd_idx[p] = lk_idx[p];
    l1d_load_pipe #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFF_W(OFF_W), .WSEL_W(WSEL_W), .IDX_W(IDX_W)
    ) u_pipe (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_valid_i  (ld_req_valid_i[p]),
      .req_addr_i   (ld_req_addr_i[p]),
      .lk_idx_o     (lk_idx[p]),
      .lk_wsel_o    (lk_wsel[p]),
      .lk_valid_i   (tag_rd_valid[p]),
      .lk_tag_i     (tag_rd_tag[p]),
      .lk_word_i    (lk_word[p]),
      .fill_valid_i (fill_valid_i),
      .fill_idx_i   (fill_idx),
      .rsp_valid_o  (ld_rsp_valid_o[p]),
      .rsp_hit_o    (ld_rsp_hit_o[p]),
      .rsp_data_o   (ld_rsp_data_o[p]),
      .miss_valid_o (miss_valid_o[p]),
      .miss_addr_o  (miss_addr_o[p])
    );
  end

  l1d_tag_array #(.N_RD(N_TRD), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (tag_rd_idx),
    .rd_valid_o (tag_rd_valid),
    .rd_tag_o   (tag_rd_tag),
    .fill_we_i  (fill_valid_i),
    .fill_idx_i (fill_idx),
    .fill_tag_i (fill_tag)
  );

  l1d_data_array #(.N_RD(N_LD), .IDX_W(IDX_W), .WSEL_W(WSEL_W), .WORD_W(WORD_W)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (lk_idx),
    .rd_wsel_i   (lk_wsel),
    .rd_word_o   (lk_word),
    .st_we_i     (st_we),
    .st_idx_i    (st_idx),
    .st_wsel_i   (st_wsel),
    .st_data_i   (st_data_i),
    .fill_we_i   (fill_valid_i),
    .fill_idx_i  (fill_idx),
    .fill_data_i (fill_data_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wt_valid_o <= 1'b0;
      wt_addr_o  <= '0;
      wt_data_o  <= '0;
    end else begin
      wt_valid_o <= st_valid_i;
      if (st_valid_i) begin
        wt_addr_o <= st_addr_i;
        wt_data_o <= st_data_i;
      end
    end
  end

  AST_WT_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i |=> (wt_valid_o && wt_addr_o == $past(st_addr_i) && wt_data_o == $past(st_data_i))); // R6
  AST_WT_ONLY_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wt_valid_o |-> $past(st_valid_i)); // R6
endmodule

// File: tb/l1d_cache_tb.sv
`timescale 1ns/1ps
module l1d_cache_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]         ld_v;
  logic [1:0][31:0]   ld_a;
  logic [1:0]         rsp_v, rsp_h, mv;
  logic [1:0][63:0]   rsp_d;
  logic [1:0][31:0]   ma;
  logic               st_v, wt_v, f_v;
  logic [31:0]        st_a, wt_a;
  logic [63:0]        st_d, wt_d;
  logic [26:0]        f_l;
  logic [255:0]       f_d;

  l1d_cache u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_req_valid_i(ld_v), .ld_req_addr_i(ld_a),
    .ld_rsp_valid_o(rsp_v), .ld_rsp_hit_o(rsp_h), .ld_rsp_data_o(rsp_d),
    .miss_valid_o(mv), .miss_addr_o(ma),
    .st_valid_i(st_v), .st_addr_i(st_a), .st_data_i(st_d),
    .wt_valid_o(wt_v), .wt_addr_o(wt_a), .wt_data_o(wt_d),
    .fill_valid_i(f_v), .fill_line_i(f_l), .fill_data_i(f_d)
  );

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  // behavioural reference
  bit          ref_v [256];
  logic [18:0] ref_t [256];
  logic [63:0] ref_d [256][4];
  bit          pend_v [2];
  logic [31:0] pend_a [2];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tag, input int idx, input int w);
    return {tag[18:0], idx[7:0], w[1:0], 3'b000};
  endfunction

  function automatic logic [255:0] pat(input int tag, input int idx, input int salt);
    logic [255:0] r;
    for (int w = 0; w < 4; w++) r[w*64 +: 64] = {salt[15:0], tag[15:0], 8'hA5, idx[7:0], 8'h00, w[7:0]};
    return r;
  endfunction

  task automatic idle_inputs();
    ld_v = '0; ld_a = '0; st_v = 0; st_a = '0; st_d = '0; f_v = 0; f_l = '0; f_d = '0;
  endtask

  // one clock: inputs already driven; model, advance, compare
  task automatic tick();
    bit e_rv[2], e_h[2], e_mv[2];
    logic [63:0] e_d[2];
    logic [31:0] e_ma[2];
    bit e_wv;
    logic [31:0] e_wa;
    logic [63:0] e_wd;
    int fi, si;
    fi = int'(f_l[7:0]);
    for (int p = 0; p < 2; p++) begin
      int ix;
      ix = int'(pend_a[p][12:5]);
      e_rv[p] = pend_v[p];
      e_h[p]  = pend_v[p] && ref_v[ix] && ref_t[ix] == pend_a[p][31:13] && !(f_v && fi == ix);
      e_d[p]  = e_h[p] ? ref_d[ix][pend_a[p][4:3]] : 64'd0;
      e_mv[p] = pend_v[p] && !e_h[p];
      e_ma[p] = pend_a[p];
    end
    e_wv = st_v; e_wa = st_a; e_wd = st_d;
    si = int'(st_a[12:5]);
    if (st_v && ref_v[si] && ref_t[si] == st_a[31:13] && !(f_v && fi == si))
      ref_d[si][st_a[4:3]] = st_d;
    if (f_v) begin
      ref_v[fi] = 1; ref_t[fi] = f_l[26:8];
      for (int w = 0; w < 4; w++) ref_d[fi][w] = f_d[w*64 +: 64];
    end
    for (int p = 0; p < 2; p++) begin pend_v[p] = ld_v[p]; pend_a[p] = ld_a[p]; end
    @(posedge clk); @(negedge clk);
    idle_inputs();
    for (int p = 0; p < 2; p++) begin
      chk(rsp_v[p] == e_rv[p], "R2", $sformatf("lane%0d rsp_valid", p), 64'(rsp_v[p]), 64'(e_rv[p]));
      chk(rsp_h[p] == e_h[p], cur_req, $sformatf("lane%0d hit", p), 64'(rsp_h[p]), 64'(e_h[p]));
      chk(rsp_d[p] == e_d[p], cur_req, $sformatf("lane%0d data", p), rsp_d[p], e_d[p]);
      chk(mv[p] == e_mv[p], "R8", $sformatf("lane%0d miss_valid", p), 64'(mv[p]), 64'(e_mv[p]));
      if (e_mv[p]) chk(ma[p] == e_ma[p], "R8", $sformatf("lane%0d miss_addr", p), 64'(ma[p]), 64'(e_ma[p]));
    end
    chk(wt_v == e_wv, "R6", "wt_valid", 64'(wt_v), 64'(e_wv));
    if (e_wv) begin
      chk(wt_a == e_wa, "R6", "wt_addr", 64'(wt_a), 64'(e_wa));
      chk(wt_d == e_wd, "R6", "wt_data", wt_d, e_wd);
    end
  endtask

  task automatic do_fill(input int tag, input int idx, input int salt);
    f_v = 1; f_l = {tag[18:0], idx[7:0]}; f_d = pat(tag, idx, salt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_v[i] = 0;
    pend_v[0] = 0; pend_v[1] = 0; pend_a[0] = '0; pend_a[1] = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(rsp_v == 2'b00 && mv == 2'b00 && !wt_v, "R1", "outputs in reset", 64'({rsp_v, mv, wt_v}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    ld_v = 2'b11; ld_a[0] = mk(1, 5, 0); ld_a[1] = mk(7, 200, 3); tick();
    tick(); tick();

    cur_req = "R4";
    do_fill(1, 5, 11); tick();
    for (int w = 0; w < 4; w++) begin ld_v = 2'b11; ld_a[0] = mk(1, 5, w); ld_a[1] = mk(1, 5, 3 - w); tick(); end
    // R11-free: low byte offset bits select nothing (R4)
    ld_v = 2'b01; ld_a[0] = mk(1, 5, 2) | 32'h7; tick();
    tick(); tick();

    cur_req = "R3";
    do_fill(2, 9, 12); tick();
    ld_v = 2'b11; ld_a[0] = mk(1, 5, 1); ld_a[1] = mk(2, 9, 1); tick();
    ld_v = 2'b11; ld_a[0] = mk(2, 9, 2); ld_a[1] = mk(2, 9, 2); tick();
    tick(); tick();

    cur_req = "R8";
    ld_v = 2'b11; ld_a[0] = mk(3, 40, 0); ld_a[1] = mk(1, 5, 0); tick();
    ld_v = 2'b11; ld_a[0] = mk(2, 9, 3); ld_a[1] = mk(3, 41, 1); tick();
    ld_v = 2'b01; ld_a[0] = mk(1, 5, 3); tick();
    tick(); tick();

    cur_req = "R5";
    st_v = 1; st_a = mk(1, 5, 2); st_d = 64'hDEAD_BEEF_0000_0001;
    ld_v = 2'b11; ld_a[0] = mk(1, 5, 2); ld_a[1] = mk(1, 5, 1); tick();
    ld_v = 2'b10; ld_a[1] = mk(1, 5, 2); tick();
    tick(); tick();

    cur_req = "R7";
    st_v = 1; st_a = mk(4, 77, 1); st_d = 64'h1234; tick();
    ld_v = 2'b01; ld_a[0] = mk(4, 77, 1); tick();
    st_v = 1; st_a = mk(5, 5, 0); st_d = 64'h55; tick();
    ld_v = 2'b10; ld_a[1] = mk(1, 5, 0); tick();
    tick(); tick();

    cur_req = "R9";
    ld_v = 2'b11; ld_a[0] = mk(1, 5, 0); ld_a[1] = mk(2, 9, 0); tick();
    do_fill(1, 5, 99); tick();
    ld_v = 2'b01; ld_a[0] = mk(1, 5, 0); tick();
    tick(); tick();

    cur_req = "R10";
    do_fill(6, 9, 33); tick();
    ld_v = 2'b11; ld_a[0] = mk(2, 9, 0); ld_a[1] = mk(6, 9, 0); tick();
    tick(); tick();

    cur_req = "R3";
    for (int c = 0; c < 3000; c++) begin
      int tg, ix;
      for (int p = 0; p < 2; p++) begin
        ld_v[p] = $urandom_range(0, 1);
        ld_a[p] = mk($urandom_range(0, 2), 3 + $urandom_range(0, 2), $urandom_range(0, 3));
      end
      if ($urandom_range(0, 3) == 0) begin
        st_v = 1; st_a = mk($urandom_range(0, 2), 3 + $urandom_range(0, 2), $urandom_range(0, 3));
        st_d = {$urandom, $urandom};
      end
      if ($urandom_range(0, 5) == 0) begin
        tg = $urandom_range(0, 2); ix = 3 + $urandom_range(0, 2);
        do_fill(tg, ix, c);
      end
      tick();
    end
    tick(); tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule